// File: doc/BRIEF.md
# Video Control Command Interpreter

This block sits behind a byte-level serial bus front end in a video input path. The first byte after a write address is taken as a one-byte command. Most commands set or clear a single bit of an 8-bit control/status register. A few commands reset that register. Others arm a load of the 8-bit filter cutoff code from the byte that follows, pick one of three input channels, or choose which register a following read returns. The front end reports each received byte as a strobe with a first-byte flag. It also reports an abort when a stop or error cuts a transfer short, and a strobe for every new START that carries a write address.

The register contents leave the block as decoded control lines for the analog side: power-down, filter bypass, sync source, sync polarity, composite mode, three clamp levels, the cutoff code and a 2-bit input select. The byte for the next read is presented on a separate output. The registers stay live in power-down, so the bus can still change settings and wake the path. Waking resumes with every stored value intact.

Top module: `vid_cmd_interp`

## Requirements
- R1: Command 00h sets the power-down bit (status bit 4, `pwr_down_o`) and 01h clears it. The registers keep working while power-down is set, and clearing it leaves every other stored value as it was.
- R2: Commands 02h to 07h set a clamp level. Bits 2:1 of the command pick the input (01 = input 1, 10 = input 2, 11 = input 3), and bit 0 = 1 selects high. Input 1 is stored in status bit 2, input 2 in bit 1 and input 3 in bit 0. `clamp_hi_o[0]` carries input 1, `[1]` input 2 and `[2]` input 3.
- R3: In commands 08h/09h, 0Ah/0Bh, 0Ch/0Dh and 0Eh/0Fh, bit 0 = 1 selects composite mode (status bit 7), external sync (bit 6), negative sync polarity (bit 5) and filter bypass (bit 3) respectively. A command changes no other status bit.
- R4: After reset the status register is 03h, the cutoff code is FFh and the channel register is 00h. Command 10h returns status to 03h and leaves the cutoff code and the channel register unchanged.
- R5: Command 12h arms a load, and the next non-first byte is written to the cutoff code. An abort before that byte cancels the load and keeps the old code. A non-first byte with no load armed is ignored.
- R6: Commands 14h, 15h and 16h write 00h, 40h and 80h to the channel register. `in_sel_o` equals its bits 7:6 (00 = A, 01 = B, 10 = C).
- R7: Commands 11h, 13h and 17h make `rd_data_o` show the status register, the cutoff code or the channel register. The output follows later changes of the selected register.
- R8: A write START strobe cancels any armed load and returns the read selection to the status register. Status is also the selection after reset.
- R9: A command of 18h or above is accepted and changes no register and no read selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| byte_valid_i | input | 1 | One-cycle strobe: a byte was received |
| byte_first_i | input | 1 | The strobed byte is the first byte after a write address |
| byte_data_i | input | 8 | Received byte |
| abort_i | input | 1 | One-cycle strobe: the current transfer was cut short |
| wr_start_i | input | 1 | One-cycle strobe: START with a matching write address |
| pwr_down_o | output | 1 | Analog power-down request |
| bypass_o | output | 1 | Filter bypass |
| ext_sync_o | output | 1 | 1 = external sync source |
| sync_neg_o | output | 1 | 1 = negative external sync polarity |
| composite_o | output | 1 | 1 = composite input, burst filter on |
| clamp_hi_o | output | 3 | Clamp level high for inputs 1..3 (bit 0 = input 1) |
| cutoff_o | output | 8 | Filter cutoff code |
| in_sel_o | output | 2 | Input channel select |
| rd_data_o | output | 8 | Byte returned by the next read |

## Verification
The assertions check on every cycle that a command changes at most one status bit and that a status reset lands on 03h. They also check that an abort never changes the cutoff code, that the channel register only takes legal codes, and that a write START returns reads to status. They further confirm that reserved commands and the status reset leave the other registers alone. Only the bench scenarios can show the opcode-to-bit mapping itself. The same holds for the two-byte load and its cancellation by abort or a new START, for read selection following register updates, and for settings surviving a power-down and wake cycle.

// File: rtl/vci_pkg.sv
package vci_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_IN  = 3;
  localparam int unsigned IDX_W   = $clog2(BYTE_W);

  // status bit positions
  localparam int unsigned ST_COMPOSITE = 7;
  localparam int unsigned ST_EXTSYNC   = 6;
  localparam int unsigned ST_NEGPOL    = 5;
  localparam int unsigned ST_PWRDN     = 4;
  localparam int unsigned ST_BYPASS    = 3;
  localparam int unsigned ST_CLAMP1    = 2; // input k at ST_CLAMP1-k

  localparam logic [BYTE_W-1:0] OP_SRST  = 8'h10;
  localparam logic [BYTE_W-1:0] OP_RD_ST = 8'h11;
  localparam logic [BYTE_W-1:0] OP_LD_FR = 8'h12;
  localparam logic [BYTE_W-1:0] OP_RD_FR = 8'h13;
  localparam logic [BYTE_W-1:0] OP_IN_A  = 8'h14;
  localparam logic [BYTE_W-1:0] OP_IN_B  = 8'h15;
  localparam logic [BYTE_W-1:0] OP_IN_C  = 8'h16;
  localparam logic [BYTE_W-1:0] OP_RD_CH = 8'h17;

  typedef enum logic [1:0] {
    RSEL_STATUS = 2'd0,
    RSEL_FREQ   = 2'd1,
    RSEL_CHAN   = 2'd2
  } rsel_e;

  typedef struct packed {
    logic             st_wr;
    logic [IDX_W-1:0] st_idx;
    logic             st_val;
    logic             st_rst;
    logic             arm_freq;
    logic             ch_wr;
    logic [1:0]       ch_val;
    logic             rd_req;
    rsel_e            rd_sel;
  } cmd_t;
endpackage

// File: rtl/vci_cmd_decode.sv
module vci_cmd_decode
  import vci_pkg::*;
(
  input  logic [BYTE_W-1:0] op_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o        = '0;
    cmd_o.rd_sel = RSEL_STATUS;
    if (op_i[7:4] == 4'h0) begin
      cmd_o.st_wr  = 1'b1;
      cmd_o.st_val = op_i[0];
      unique case (op_i[3:1])
        3'd0: begin
          cmd_o.st_idx = IDX_W'(ST_PWRDN);
          cmd_o.st_val = ~op_i[0]; // 00h powers down
        end
        3'd1: cmd_o.st_idx = IDX_W'(ST_CLAMP1);
        3'd2: cmd_o.st_idx = IDX_W'(ST_CLAMP1 - 1);
        3'd3: cmd_o.st_idx = IDX_W'(ST_CLAMP1 - 2);
        3'd4: cmd_o.st_idx = IDX_W'(ST_COMPOSITE);
        3'd5: cmd_o.st_idx = IDX_W'(ST_EXTSYNC);
        3'd6: cmd_o.st_idx = IDX_W'(ST_NEGPOL);
        default: cmd_o.st_idx = IDX_W'(ST_BYPASS);
      endcase
    end else begin
      unique case (op_i)
        OP_SRST:  cmd_o.st_rst   = 1'b1;
        OP_LD_FR: cmd_o.arm_freq = 1'b1;
        OP_IN_A: begin cmd_o.ch_wr = 1'b1; cmd_o.ch_val = 2'b00; end
        OP_IN_B: begin cmd_o.ch_wr = 1'b1; cmd_o.ch_val = 2'b01; end
        OP_IN_C: begin cmd_o.ch_wr = 1'b1; cmd_o.ch_val = 2'b10; end
        OP_RD_ST: begin cmd_o.rd_req = 1'b1; cmd_o.rd_sel = RSEL_STATUS; end
        OP_RD_FR: begin cmd_o.rd_req = 1'b1; cmd_o.rd_sel = RSEL_FREQ; end
        OP_RD_CH: begin cmd_o.rd_req = 1'b1; cmd_o.rd_sel = RSEL_CHAN; end
        default: ; // reserved: accepted, no action (R9)
      endcase
    end
  end

  // at most one action per opcode (R9)
  always_comb begin
    assert_one_action_R9: assert ($onehot0({cmd_o.st_wr, cmd_o.st_rst, cmd_o.arm_freq,
                                            cmd_o.ch_wr, cmd_o.rd_req}))
      else $error("decoder raised several actions");
  end
endmodule

// File: rtl/vci_status_reg.sv
module vci_status_reg
  import vci_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              val_i,
  input  logic              srst_i,
  output logic [BYTE_W-1:0] status_o
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              status_o[i] <= RST_VAL[i];
      else if (srst_i)                          status_o[i] <= RST_VAL[i];
      else if (upd_i && idx_i == IDX_W'(i))     status_o[i] <= val_i;
    end
  end

  assert_one_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> $countones(status_o ^ $past(status_o)) <= 1);

  assert_srst_val_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> status_o == RST_VAL);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !srst_i) |=> $stable(status_o));
endmodule

// File: rtl/vci_data_regs.sv
module vci_data_regs
  import vci_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FREQ_RST = 8'hFF,
  parameter logic [BYTE_W-1:0] CHAN_RST = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_fire_i,
  input  logic              data_fire_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              arm_i,
  input  logic              cancel_i,
  input  logic              ch_wr_i,
  input  logic [1:0]        ch_val_i,
  output logic [BYTE_W-1:0] freq_o,
  output logic [BYTE_W-1:0] chan_o
);
  logic pend_q, load;

  assign load = data_fire_i && pend_q && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (cancel_i)    pend_q <= 1'b0;
    else if (cmd_fire_i)  pend_q <= arm_i;
    else if (data_fire_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   freq_o <= FREQ_RST;
    else if (load) freq_o <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    chan_o <= CHAN_RST;
    else if (cmd_fire_i && ch_wr_i) chan_o <= {ch_val_i, {(BYTE_W-2){1'b0}}};
  end

  assert_abort_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> freq_o == $past(freq_o));

  assert_load_only_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_fire_i |=> $stable(freq_o));

  assert_chan_fmt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_o[BYTE_W-3:0] == '0 && chan_o[BYTE_W-1 -: 2] != 2'b11);
endmodule

// File: rtl/vci_read_sel.sv
module vci_read_sel
  import vci_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wstart_i,
  input  logic              req_i,
  input  rsel_e             sel_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] freq_i,
  input  logic [BYTE_W-1:0] chan_i,
  output logic [BYTE_W-1:0] rd_o
);
  rsel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= RSEL_STATUS;
    else if (wstart_i) sel_q <= RSEL_STATUS;
    else if (req_i)    sel_q <= sel_i;
  end

  always_comb begin
    unique case (sel_q)
      RSEL_FREQ: rd_o = freq_i;
      RSEL_CHAN: rd_o = chan_i;
      default:   rd_o = status_i;
    endcase
  end

  assert_wstart_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wstart_i |=> rd_o == status_i);
endmodule

// File: rtl/vid_cmd_interp.sv
module vid_cmd_interp
  import vci_pkg::*;
#(
  parameter logic [BYTE_W-1:0] STATUS_RST = 8'h03,
  parameter logic [BYTE_W-1:0] FREQ_RST   = 8'hFF,
  parameter logic [BYTE_W-1:0] CHAN_RST   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic              byte_first_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              abort_i,
  input  logic              wr_start_i,
  output logic              pwr_down_o,
  output logic              bypass_o,
  output logic              ext_sync_o,
  output logic              sync_neg_o,
  output logic              composite_o,
  output logic [NUM_IN-1:0] clamp_hi_o,
  output logic [BYTE_W-1:0] cutoff_o,
  output logic [1:0]        in_sel_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  cmd_t              cmd;
  logic              cmd_fire, data_fire;
  logic [BYTE_W-1:0] status, chan;

  assign cmd_fire  = byte_valid_i && byte_first_i;
  assign data_fire = byte_valid_i && !byte_first_i;

  vci_cmd_decode u_dec (
    .op_i  (byte_data_i),
    .cmd_o (cmd)
  );

  vci_status_reg #(.RST_VAL(STATUS_RST)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (cmd_fire && cmd.st_wr),
    .idx_i    (cmd.st_idx),
    .val_i    (cmd.st_val),
    .srst_i   (cmd_fire && cmd.st_rst),
    .status_o (status)
  );

  vci_data_regs #(.FREQ_RST(FREQ_RST), .CHAN_RST(CHAN_RST)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_fire_i  (cmd_fire),
    .data_fire_i (data_fire),
    .data_i      (byte_data_i),
    .arm_i       (cmd.arm_freq),
    .cancel_i    (abort_i || wr_start_i),
    .ch_wr_i     (cmd.ch_wr),
    .ch_val_i    (cmd.ch_val),
    .freq_o      (cutoff_o),
    .chan_o      (chan)
  );

  vci_read_sel u_rsel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wstart_i (wr_start_i),
    .req_i    (cmd_fire && cmd.rd_req),
    .sel_i    (cmd.rd_sel),
    .status_i (status),
    .freq_i   (cutoff_o),
    .chan_i   (chan),
    .rd_o     (rd_data_o)
  );

  assign pwr_down_o  = status[ST_PWRDN];
  assign bypass_o    = status[ST_BYPASS];
  assign ext_sync_o  = status[ST_EXTSYNC];
  assign sync_neg_o  = status[ST_NEGPOL];
  assign composite_o = status[ST_COMPOSITE];
  assign in_sel_o    = chan[BYTE_W-1 -: 2];

  for (genvar k = 0; k < NUM_IN; k++) begin : g_clamp
    assign clamp_hi_o[k] = status[ST_CLAMP1-k];
  end

  assert_srst_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && byte_data_i == OP_SRST) |=> $stable(cutoff_o) && $stable(in_sel_o));

  assert_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_fire && byte_data_i >= 8'h18 && !wr_start_i)
      |=> $stable(cutoff_o) && $stable(in_sel_o) && $stable(rd_data_o) && $stable(pwr_down_o));
endmodule

// File: tb/tb_vid_cmd_interp.sv
module tb_vid_cmd_interp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bv = 1'b0, bf = 1'b0, ab = 1'b0, ws = 1'b0;
  logic [7:0] bd = 8'h00;
  logic       pd, byp, ext, neg, comp;
  logic [2:0] clamp;
  logic [7:0] cut, rd;
  logic [1:0] isel;

  always #5 clk = ~clk;

  vid_cmd_interp dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(bv), .byte_first_i(bf),
    .byte_data_i(bd), .abort_i(ab), .wr_start_i(ws),
    .pwr_down_o(pd), .bypass_o(byp), .ext_sync_o(ext), .sync_neg_o(neg),
    .composite_o(comp), .clamp_hi_o(clamp), .cutoff_o(cut), .in_sel_o(isel),
    .rd_data_o(rd)
  );

  typedef struct {
    logic [7:0] st;
    logic [7:0] fr;
    logic [7:0] ch;
    logic [7:0] rdv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // reference model
  logic [7:0] m_st = 8'h03, m_fr = 8'hFF, m_ch = 8'h00;
  int         m_rs = 0;
  bit         m_pend = 0;

  task automatic push(string tag);
    exp_t e;
    e.st = m_st; e.fr = m_fr; e.ch = m_ch; e.tag = tag;
    e.rdv = (m_rs == 1) ? m_fr : (m_rs == 2) ? m_ch : m_st;
    q.push_back(e);
  endtask

  task automatic strobe(logic v, logic f, logic [7:0] d, logic a, logic w);
    @(negedge clk);
    bv = v; bf = f; bd = d; ab = a; ws = w;
    @(negedge clk);
    bv = 0; bf = 0; ab = 0; ws = 0;
  endtask

  task automatic cmd(logic [7:0] b, string tag);
    m_pend = 0;
    case (b)
      8'h00: m_st[4] = 1; 8'h01: m_st[4] = 0;
      8'h02: m_st[2] = 0; 8'h03: m_st[2] = 1;
      8'h04: m_st[1] = 0; 8'h05: m_st[1] = 1;
      8'h06: m_st[0] = 0; 8'h07: m_st[0] = 1;
      8'h08: m_st[7] = 0; 8'h09: m_st[7] = 1;
      8'h0A: m_st[6] = 0; 8'h0B: m_st[6] = 1;
      8'h0C: m_st[5] = 0; 8'h0D: m_st[5] = 1;
      8'h0E: m_st[3] = 0; 8'h0F: m_st[3] = 1;
      8'h10: m_st = 8'h03;
      8'h11: m_rs = 0;
      8'h12: m_pend = 1;
      8'h13: m_rs = 1;
      8'h14: m_ch = 8'h00; 8'h15: m_ch = 8'h40; 8'h16: m_ch = 8'h80;
      8'h17: m_rs = 2;
      default: ;
    endcase
    strobe(1, 1, b, 0, 0);
    push(tag);
  endtask

  task automatic data(logic [7:0] b, string tag);
    if (m_pend) m_fr = b;
    m_pend = 0;
    strobe(1, 0, b, 0, 0);
    push(tag);
  endtask

  task automatic abort_x(string tag);
    m_pend = 0;
    strobe(0, 0, 8'h00, 1, 0);
    push(tag);
  endtask

  task automatic wstart(string tag);
    m_pend = 0; m_rs = 0;
    strobe(0, 0, 8'h00, 0, 1);
    push(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] st_a;
        e = q.pop_front();
        st_a = {comp, ext, neg, pd, byp, clamp[0], clamp[1], clamp[2]};
        total++;
        if (st_a !== e.st || cut !== e.fr || isel !== e.ch[7:6] || rd !== e.rdv) begin
          bad++;
          $display("FAIL %s: st=%h fr=%h sel=%b rd=%h expected st=%h fr=%h sel=%b rd=%h",
                   e.tag, st_a, cut, isel, rd, e.st, e.fr, e.ch[7:6], e.rdv);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R4 reset values");

    cmd(8'h00, "R1 power down");
    cmd(8'h01, "R1 wake");
    cmd(8'h03, "R2 clamp in1 high");
    cmd(8'h04, "R2 clamp in2 low");
    cmd(8'h06, "R2 clamp in3 low");
    cmd(8'h07, "R2 clamp in3 high");
    cmd(8'h09, "R3 composite");
    cmd(8'h0B, "R3 external sync");
    cmd(8'h0D, "R3 negative polarity");
    cmd(8'h0F, "R3 bypass");
    cmd(8'h0E, "R3 filters on");
    cmd(8'h0A, "R3 internal sync");

    cmd(8'h12, "R5 arm load");
    data(8'h5A, "R5 load data");
    data(8'h33, "R5 data without arm ignored");
    cmd(8'h12, "R5 arm again");
    abort_x("R5 abort");
    data(8'h77, "R5 data after abort ignored");

    cmd(8'h15, "R6 input B");
    cmd(8'h16, "R6 input C");
    cmd(8'h14, "R6 input A");
    cmd(8'h16, "R6 input C again");

    cmd(8'h13, "R7 read freq");
    cmd(8'h12, "R7 arm while freq selected");
    data(8'hC3, "R7 read follows freq update");
    cmd(8'h17, "R7 read chan");
    cmd(8'h11, "R7 read status");
    cmd(8'h17, "R8 read chan before start");
    wstart("R8 start returns status read");
    cmd(8'h12, "R8 arm");
    wstart("R8 start cancels arm");
    data(8'h11, "R8 data after start ignored");

    cmd(8'h10, "R4 soft reset keeps freq/chan");

    cmd(8'h00, "R1 power down again");
    cmd(8'h12, "R1 arm in power down");
    data(8'h21, "R1 load in power down");
    cmd(8'h15, "R1 chan in power down");
    cmd(8'h01, "R1 wake keeps settings");

    cmd(8'h13, "R9 select freq");
    cmd(8'h18, "R9 reserved 18h");
    cmd(8'h2A, "R9 reserved 2Ah");
    cmd(8'hFF, "R9 reserved FFh");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule